// File: doc/BRIEF.md
# Threshold-Interrupt Byte FIFO for Programmed I/O

A sixteen-entry, byte-wide FIFO placed between a host register interface and a peripheral data path. A direction input selects which side fills it and which side drains it: in the forward direction the host writes bytes and the peripheral pops them; in the reverse direction the peripheral pushes bytes and the host reads them. Strobes from the side that is not active in the current direction have no effect.

A service interrupt tells the host when a programmed-I/O burst is worthwhile. The comparison depends on the direction and on a 4-bit threshold `thresh`. In the reverse direction the request is raised when at least `16 - thresh` bytes are waiting. In the forward direction it is raised when no more than `thresh` bytes are held, so at least `16 - thresh` slots are free. A full FIFO in the reverse direction, or an empty one in the forward direction, allows a burst of all sixteen bytes.

The request is gated by an active-low service bit. Raising the interrupt sets the bit, so each arming yields a single one-cycle pulse. The host re-arms the interrupt by writing 0 to the bit.

Top module: `tif_fifo`

## Requirements
- R1: After synchronous reset `count` is 0, `empty` is 1, `full` is 0, `irq` is 0 and `svc` is 1 (disarmed).
- R2: With `dir`=0 (forward) `host_wr` pushes `host_wdata` and `per_pop` pops; with `dir`=1 (reverse) `per_push` pushes `per_wdata` and `host_rd` pops. The other two strobes leave `count` and the stored data unchanged.
- R3: Bytes leave in the order they were accepted; the popped byte appears on `rd_data` in the cycle after the pop edge.
- R4: A push while full without an accepted pop is dropped: `count` stays 16 and the stored bytes are unchanged.
- R5: A pop while empty is ignored: `count` stays 0 and `rd_data` keeps its previous value.
- R6: A push and an accepted pop at the same edge leave `count` unchanged and keep the byte order. This includes the full case. When the FIFO is empty only the push is taken.
- R7: `count` ranges over 0..16 and updates at the edge that samples the strobes. `full` is 1 exactly when `count` is 16 and `empty` is 1 exactly when `count` is 0.
- R8: In the reverse direction the interrupt condition is `count >= 16 - thresh`. For example, with `thresh`=12 it holds at 4 to 16 bytes, and with `thresh`=0 it holds only when full.
- R9: In the forward direction the interrupt condition is `count <= thresh`. For example, with `thresh`=0 it holds only when empty.
- R10: At an edge where `svc` is 0 and the condition holds on the count before that edge, `irq` becomes 1 and `svc` becomes 1. `irq` is therefore a one-cycle pulse and is never 1 while armed.
- R11: `svc_we` loads `svc_wd` into `svc` at the next edge. This write takes precedence over the interrupt, so `irq` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | 0 = forward (host fills), 1 = reverse (peripheral fills) |
| thresh | input | 4 | Interrupt threshold |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| per_push | input | 1 | Peripheral push strobe |
| per_wdata | input | 8 | Peripheral push byte |
| per_pop | input | 1 | Peripheral pop strobe |
| svc_we | input | 1 | Service bit write strobe |
| svc_wd | input | 1 | Service bit write value |
| rd_data | output | 8 | Byte popped at the previous edge |
| count | output | 5 | Stored byte count, 0..16 |
| full | output | 1 | Count is 16 |
| empty | output | 1 | Count is 0 |
| irq | output | 1 | Service interrupt pulse |
| svc | output | 1 | Service bit, 0 = armed |

## Verification
The bench targets the exact threshold boundaries in both directions, including thresholds 0, 12 and 15. An off-by-one compare would move the pulse by one byte, which the cycle-exact interrupt model catches. It pushes while full and pops while empty. A design that wrapped its pointers or count there would corrupt the byte order that the scoreboard checks, or would change `rd_data`. It drives simultaneous push and pop at empty, at full and mid-level; a design that gave the push priority wrongly would drift the count. It also checks that a service write at the same edge as a true condition suppresses the pulse; a design without that precedence would emit a spurious interrupt.

// File: rtl/tif_pkg.sv
package tif_pkg;
  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } tif_dir_e;
endpackage

// File: rtl/tif_mem.sv
module tif_mem #(
  parameter int DW = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tif_ctrl.sv
module tif_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);
  localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);

  logic          pop_ok, push_ok;
  logic [CW-1:0] count_n;

  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign we      = push_ok;
  assign re      = pop_ok;

  always_comb begin
    count_n = count;
    if (push_ok && !pop_ok) count_n = count + 1'b1;
    else if (pop_ok && !push_ok) count_n = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waddr <= '0;
      raddr <= '0;
      count <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (push_ok) waddr <= (waddr == PLAST) ? '0 : waddr + 1'b1;
      if (pop_ok)  raddr <= (raddr == PLAST) ? '0 : raddr + 1'b1;
      count <= count_n;
      full  <= (count_n == CMAX);
      empty <= (count_n == '0);
    end
  end

  a_r7_count_range: assert property (@(posedge clk) disable iff (rst)
    count <= CMAX);
  a_r7_flags_track: assert property (@(posedge clk) disable iff (rst)
    (full == (count == CMAX)) && (empty == (count == '0)));
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    full && push && !pop |=> count == CMAX);
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    empty && pop && !push |=> count == '0);
  a_r6_both_hold: assert property (@(posedge clk) disable iff (rst)
    push && pop && !empty |=> $stable(count));
endmodule

// File: rtl/tif_irq.sv
module tif_irq #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  tif_pkg::tif_dir_e dir,
  input  logic [AW-1:0] thresh,
  input  logic [CW-1:0] count,
  input  logic          svc_we,
  input  logic          svc_wd,
  output logic          irq,
  output logic          svc
);
  import tif_pkg::*;

  logic [CW-1:0] rd_level;
  logic          cond;

  assign rd_level = CW'(DEPTH) - CW'(thresh);
  assign cond = (dir == DIR_REV) ? (count >= rd_level) : (count <= CW'(thresh));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      svc <= 1'b1;
    end else if (svc_we) begin
      irq <= 1'b0;
      svc <= svc_wd;
    end else if (!svc && cond) begin
      irq <= 1'b1;
      svc <= 1'b1;
    end else begin
      irq <= 1'b0;
    end
  end

  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  a_r10_gate: assert property (@(posedge clk) disable iff (rst)
    irq |-> svc && !$past(svc));
  a_r11_load: assert property (@(posedge clk) disable iff (rst)
    svc_we |=> (svc == $past(svc_wd)) && !irq);
endmodule

// File: rtl/tif_fifo.sv
module tif_fifo #(
  parameter int DW = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir,
  input  logic [AW-1:0] thresh,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  input  logic          per_push,
  input  logic [DW-1:0] per_wdata,
  input  logic          per_pop,
  input  logic          svc_we,
  input  logic          svc_wd,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          irq,
  output logic          svc
);
  import tif_pkg::*;

  tif_dir_e      dir_e;
  logic          push, pop, we, re;
  logic [DW-1:0] wdata;
  logic [AW-1:0] waddr, raddr;

  assign dir_e = tif_dir_e'(dir);
  assign push  = (dir_e == DIR_REV) ? per_push  : host_wr;
  assign pop   = (dir_e == DIR_REV) ? host_rd   : per_pop;
  assign wdata = (dir_e == DIR_REV) ? per_wdata : host_wdata;

  tif_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .we(we), .waddr(waddr), .re(re), .raddr(raddr),
    .count(count), .full(full), .empty(empty)
  );

  tif_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .re(re), .raddr(raddr), .rdata(rd_data)
  );

  tif_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst(rst), .dir(dir_e), .thresh(thresh), .count(count),
    .svc_we(svc_we), .svc_wd(svc_wd), .irq(irq), .svc(svc)
  );

  a_r2_idle_side: assert property (@(posedge clk) disable iff (rst)
    !push && !pop && !svc_we |=> $stable(count));
endmodule

// File: tb/test_tif_fifo.sv
module test_tif_fifo;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir = 1'b0;
  logic [3:0] thresh = 4'd12;
  logic       host_wr = 0, host_rd = 0, per_push = 0, per_pop = 0;
  logic       svc_we = 0, svc_wd = 0;
  logic [7:0] host_wdata = 0, per_wdata = 0;
  logic [7:0] rd_data;
  logic [4:0] count;
  logic       full, empty, irq, svc;

  always #10 clk = ~clk;

  tif_fifo i_tif_fifo (
    .clk(clk), .rst(rst), .dir(dir), .thresh(thresh),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .per_push(per_push), .per_wdata(per_wdata), .per_pop(per_pop),
    .svc_we(svc_we), .svc_wd(svc_wd), .rd_data(rd_data), .count(count),
    .full(full), .empty(empty), .irq(irq), .svc(svc)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  int   m_cnt = 0;
  bit   m_svc = 1, m_irq = 0;
  bit   cur_dir = 0;
  int   cur_th = 12;
  logic [7:0] last_rd = 0;
  bit   chk_pop = 0, chk_hold = 0, done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: check outputs against model, apply strobes, advance model
  task automatic step(input bit hw, input bit hr, input bit pp, input bit pq,
                      input bit sw, input bit swd, input logic [7:0] d,
                      input string ctag, input string itag);
    bit push, pop, pop_ok, push_ok, cond;
    @(negedge clk);
    chk({ctag, " count"}, int'(count), m_cnt);
    chk({ctag, " full"}, int'(full), int'(m_cnt == 16));
    chk({ctag, " empty"}, int'(empty), int'(m_cnt == 0));
    chk({itag, " irq"}, int'(irq), int'(m_irq));
    chk({itag, " svc"}, int'(svc), int'(m_svc));
    dir = cur_dir; thresh = 4'(cur_th);
    host_wr = hw; host_rd = hr; per_push = pp; per_pop = pq;
    svc_we = sw; svc_wd = swd; host_wdata = d; per_wdata = d;
    push = cur_dir ? pp : hw;
    pop  = cur_dir ? hr : pq;
    pop_ok  = pop && (m_cnt != 0);
    push_ok = push && ((m_cnt != 16) || pop_ok);
    cond = cur_dir ? (m_cnt >= 16 - cur_th) : (m_cnt <= cur_th);
    if (sw) begin m_svc = swd; m_irq = 0; end
    else if (!m_svc && cond) begin m_irq = 1; m_svc = 1; end
    else m_irq = 0;
    if (push_ok) exp_q.push_back(d);
    m_cnt = m_cnt + int'(push_ok) - int'(pop_ok);
    @(posedge clk);
    if (pop_ok) chk_pop = 1;
    else if (pop) chk_hold = 1;
  endtask

  // monitor: compares popped bytes against the scoreboard queue
  always @(negedge clk) begin
    if (chk_pop) begin
      chk_pop = 0;
      if (exp_q.size() == 0) chk("R3 queue", 1, 0);
      else chk("R3 data", int'(rd_data), int'(exp_q.pop_front()));
      last_rd = rd_data;
    end else if (chk_hold) begin
      chk_hold = 0;
      chk("R5 rd_data held", int'(rd_data), int'(last_rd));
    end
  end

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 8'h00, tag, tag);
  endtask
  task automatic arm(input string tag);
    step(0, 0, 0, 0, 1, 0, 8'h00, "R11", tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    idle(1, "R1");

    // forward, threshold 12
    cur_dir = 0; cur_th = 12;
    arm("R11");
    idle(2, "R9");
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0, 8'(8'hA0 + i), "R2", "R9");
    step(1, 0, 0, 0, 0, 0, 8'hEE, "R4", "R9");
    step(0, 0, 1, 0, 0, 0, 8'hDD, "R2", "R9");
    step(0, 1, 0, 0, 0, 0, 8'h00, "R2", "R9");
    arm("R9");
    idle(1, "R4");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 0, 0, 8'h00, "R3", "R9");
    step(0, 0, 0, 1, 0, 0, 8'h00, "R5", "R9");
    idle(2, "R5");

    // reverse, threshold 12
    cur_dir = 1; cur_th = 12;
    arm("R8");
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0, 0, 8'(8'h10 + i), "R2", "R8");
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 0, 0, 8'(8'h30 + i), "R6", "R8");
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 0, 0, 8'h00, "R3", "R8");
    step(0, 1, 1, 0, 0, 0, 8'h55, "R6", "R8");
    step(0, 1, 0, 0, 0, 0, 8'h00, "R3", "R8");
    idle(1, "R7");

    // reverse, threshold 0: interrupt only when full
    cur_th = 0;
    arm("R8");
    for (int i = 0; i < 16; i++) step(0, 0, 1, 0, 0, 0, 8'(8'h60 + i), "R7", "R8");
    idle(2, "R8");
    step(0, 1, 1, 0, 0, 0, 8'h99, "R6", "R8");
    step(0, 0, 0, 0, 1, 0, 8'h00, "R11", "R11");
    step(0, 0, 0, 0, 1, 0, 8'h00, "R11", "R10");
    idle(2, "R10");
    for (int i = 0; i < 16; i++) step(0, 1, 0, 0, 0, 0, 8'h00, "R3", "R10");
    idle(1, "R7");

    // forward, threshold 15 and 0
    cur_dir = 0; cur_th = 15;
    arm("R9");
    idle(1, "R9");
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0, 8'(8'hC0 + i), "R7", "R9");
    arm("R9");
    idle(1, "R9");
    step(0, 0, 0, 1, 0, 0, 8'h00, "R3", "R9");
    idle(2, "R10");
    cur_th = 0;
    arm("R9");
    for (int i = 0; i < 15; i++) step(0, 0, 0, 1, 0, 0, 8'h00, "R3", "R9");
    step(1, 0, 0, 1, 0, 0, 8'h77, "R6", "R9");
    step(0, 0, 0, 1, 0, 0, 8'h00, "R3", "R9");
    idle(3, "R9");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule